// File: doc/BRIEF.md
# Prioritized Timer Interrupt Vector Unit

This unit sits between the event sources of a general-purpose timer (input captures, output compares, counter overflow) and the processor's interrupt logic. Each source has one event flag. An enabled flag that is set raises a single interrupt request. The unit picks the most urgent pending source and presents an 8-bit vector number. The upper four bits of that number come from a software-written vector base. The lower four bits are the winning source number.

Software reaches three registers through a small synchronous bus. A configuration register holds the vector base and a priority-adjust field. The priority-adjust field can move one chosen source ahead of all the others. A status register holds the flags. An enable register gates which flags may request service. A flag clears only in two steps. Software first reads the status register while the flag is set, and then writes a zero to that flag's bit. If an event arrives between those two steps, the flag stays set. This prevents an event from being lost.

Top module: `tmr_irq_vector`

## Requirements
- R1: After a synchronous active-low reset, `vec_o` is 0x00, `irq_o` is 0, and the configuration (address 0), status (address 1) and enable (address 2) registers all read 0.
- R2: A one-cycle pulse on `evt_i` bit k-1 sets the flag of source k (k = 1..11). The flag is visible as status bit k-1 at address 1 whatever the enable setting.
- R3: `irq_o` is 1 while at least one flag is set with its enable bit (address 2, bit k-1) at 1, and it falls to 0 once no such flag remains.
- R4: `vec_o` equals the vector base (configuration bits 7:4) in its upper nibble and the winning source number in its lower nibble. The lower nibble is 0 when nothing is pending.
- R5: Without promotion, the pending enabled source with the lowest number wins.
- R6: When the priority-adjust field (configuration bits 3:0) equals the number of a pending enabled source, that source wins. A value of 0, a value above 11, or a value naming a source that is not pending leaves the normal order in place.
- R7: A write of 0 to a status bit clears that flag only if the status register was read while the flag was set. A write of 0 with no such earlier read leaves the flag set.
- R8: A write of 1 to a status bit leaves that flag unchanged.
- R9: An event on a source after the arming read, or in the same cycle as the clearing write, keeps that flag set.
- R10: A flag whose enable bit is 0 neither raises `irq_o` nor takes part in the vector choice.
- R11: The vector base is output exactly as written. A base of 0 yields vectors 0x00 to 0x0B.
- R12: `vec_o` and `irq_o` are registered. They reflect a change in flags or enables one clock edge after the edge on which that change takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 11 | Event pulses, bit k-1 for source k |
| bus_addr | input | 2 | Register select: 0 config, 1 status, 2 enable |
| bus_rd | input | 1 | Read strobe (arms flags when address is 1) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Vector number: base nibble, source number |

## Verification
The choice logic is tried with single pending sources, with several pending at once where the lowest number must win, and with promotion values that name a pending source, a source that is not pending, and an out-of-range code. These cases separate a true priority override from an override that is ignored or misapplied. The clear protocol is tried four ways: a zero write without a read, a proper read-then-zero, a one write after arming, and an event between the read and the write or in the same cycle as the write. Together these show whether the armed state, rather than the write alone, controls the clearing. A base of zero and disabled sources confirm that the vector is formed as written and that gating applies to both the request and the choice.

// File: rtl/tivu_pkg.sv
// Package: shared register selects and widths for the timer interrupt vector unit.
// Assumes at most 15 sources so a source number fits in one nibble.
package tivu_pkg;
    localparam int SRC_W = 4;
    localparam int VEC_W = 8;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_ENA  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tivu_reg_file.sv
// Module: configuration and enable registers written over the simple bus.
// Holds the vector base nibble, the priority-adjust nibble and the per-source
// enable mask. Assumes NUM_SRC >= 8 so every write-data bit below NUM_SRC is used.
module tivu_reg_file
    import tivu_pkg::*;
#(
    parameter int NUM_SRC = 11,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [SRC_W-1:0]   base_q,
    output logic [SRC_W-1:0]   padj_q,
    output logic [NUM_SRC-1:0] ena_q
);
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    // Purpose: capture configuration writes (base in 7:4, promote in 3:0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            padj_q <= '0;
        end else if (bus_wr && reg_sel_e'(bus_addr) == SEL_CFG) begin
            base_q <= bus_wdata[2*SRC_W-1:SRC_W];
            padj_q <= bus_wdata[SRC_W-1:0];
        end
    end

    // Purpose: capture enable-mask writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
        end else if (bus_wr && reg_sel_e'(bus_addr) == SEL_ENA) begin
            ena_q <= bus_wdata[NUM_SRC-1:0];
        end
    end

    // R4: the base nibble follows the last configuration write
    assert_base_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> base_q == $past(bus_wdata[7:4]));
endmodule

// File: rtl/tivu_flag_bank.sv
// Module: per-source event flags with a race-safe read-then-write-zero clear.
// Each source has a flag and an armed bit. A status read arms the set flags.
// A zero write clears only armed flags. An event sets the flag and disarms it,
// and it overrides a clearing write in the same cycle.
module tivu_flag_bank #(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               stat_rd,
    input  logic               stat_wr,
    input  logic [NUM_SRC-1:0] wr_bits,
    output logic [NUM_SRC-1:0] flags_q
);
    logic [NUM_SRC-1:0] armed_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        // Purpose: update flag i and its armed bit (event > clear > arm).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
                armed_q[i] <= 1'b0;
            end else if (evt_i[i]) begin
                flags_q[i] <= 1'b1;
                armed_q[i] <= 1'b0;
            end else if (stat_wr && !wr_bits[i] && armed_q[i]) begin
                flags_q[i] <= 1'b0;
                armed_q[i] <= 1'b0;
            end else if (stat_rd && flags_q[i]) begin
                armed_q[i] <= 1'b1;
            end
        end

        // R2: an event always leaves the flag set
        assert_event_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> flags_q[i]);
        // R8: a one written to the bit never changes the flag
        assert_write_one_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && wr_bits[i] && !evt_i[i]) |=> $stable(flags_q[i]));
        // R7: a flag only falls after a zero write to its bit
        assert_clear_needs_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags_q[i]) |-> $past(stat_wr && !wr_bits[i]));
        // R9: an unarmed set flag survives a zero write
        assert_unarmed_survives_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && !armed_q[i] && stat_wr) |=> flags_q[i]);
    end
endmodule

// File: rtl/tivu_prio_resolve.sv
// Module: picks the winning source number from the pending mask.
// Lowest number wins unless the promote code names a pending source.
// Output 0 means nothing pending. The clock and reset serve the checks only.
module tivu_prio_resolve
    import tivu_pkg::*;
#(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pending,
    input  logic [SRC_W-1:0]   padj,
    output logic [SRC_W-1:0]   winner
);
    logic [SRC_W-1:0]   natural_win;
    logic               promo_hit;
    logic [NUM_SRC-1:0] grant;

    // Purpose: fixed order, scanning down so the lowest index is kept last.
    always_comb begin
        natural_win = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pending[i]) natural_win = SRC_W'(i + 1);
        end
    end

    // Purpose: detect that the promote code names a pending source.
    always_comb begin
        promo_hit = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pending[i] && padj == SRC_W'(i + 1)) promo_hit = 1'b1;
        end
    end

    assign winner = promo_hit ? padj : natural_win;

    // Purpose: one-hot view of the winner for checking.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) grant[i] = (winner == SRC_W'(i + 1));
    end

    // R5: at most one source wins and it is pending
    assert_grant_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~pending) == '0));
    // R5: some source wins whenever any is pending
    assert_grant_when_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending != '0) |-> (grant != '0));
endmodule

// File: rtl/tmr_irq_vector.sv
// Module: top of the timer interrupt vector unit.
// Joins the register file, flag bank and resolver. Registers the request and
// the vector one edge after the pending set changes. Read data is combinational
// from the selected register. Assumes 8 <= NUM_SRC <= 15 and DATA_W >= NUM_SRC.
module tmr_irq_vector
    import tivu_pkg::*;
#(
    parameter int NUM_SRC = 11,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [1:0]         bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o
);
    logic [SRC_W-1:0]   base_q;
    logic [SRC_W-1:0]   padj_q;
    logic [NUM_SRC-1:0] ena_q;
    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] pending;
    logic [SRC_W-1:0]   winner;
    logic               stat_rd;
    logic               stat_wr;

    assign stat_rd = bus_rd && reg_sel_e'(bus_addr) == SEL_STAT;
    assign stat_wr = bus_wr && reg_sel_e'(bus_addr) == SEL_STAT;
    assign pending = flags_q & ena_q;

    tivu_reg_file #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .base_q    (base_q),
        .padj_q    (padj_q),
        .ena_q     (ena_q)
    );

    tivu_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .stat_rd (stat_rd),
        .stat_wr (stat_wr),
        .wr_bits (bus_wdata[NUM_SRC-1:0]),
        .flags_q (flags_q)
    );

    tivu_prio_resolve #(.NUM_SRC(NUM_SRC)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .padj    (padj_q),
        .winner  (winner)
    );

    // Purpose: register the request and the formed vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            vec_o <= '0;
        end else begin
            irq_o <= |pending;
            vec_o <= {base_q, winner};
        end
    end

    // Purpose: select read data for the addressed register.
    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_CFG:  bus_rdata = DATA_W'({base_q, padj_q});
            SEL_STAT: bus_rdata = DATA_W'(flags_q);
            SEL_ENA:  bus_rdata = DATA_W'(ena_q);
            default:  bus_rdata = '0;
        endcase
    end

    // R3: a request always carries a nonzero source number
    assert_irq_has_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> vec_o[3:0] != 4'd0);
    // R4: with no request the source nibble is zero
    assert_idle_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vec_o[3:0] == 4'd0);
    // R12: the vector base nibble lags the register by one edge
    assert_vec_base_lag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> vec_o[7:4] == $past(base_q));
endmodule

// File: tb/tmr_irq_vector_tb_top.sv
// Scoreboard bench: driver tasks queue expected observations; a monitor pops
// and compares them 2 ns after each falling edge.
module tmr_irq_vector_tb_top;
    localparam int NS = 11;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt_i = '0;
    logic [1:0]    bus_addr = 2'd3;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;
    logic [7:0]    vec_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 vec, 1 irq, 2 read data
        logic [15:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #10 clk = ~clk;   // 50 MHz

    tmr_irq_vector #(.NUM_SRC(NS), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .vec_o(vec_o)
    );

    // Monitor: compare every queued item against the current outputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                act = (it.kind == 0) ? 16'(vec_o) : (it.kind == 1) ? 16'(irq_o) : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input int kind, input logic [15:0] exp, input string tag);
        exp_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic expect_out(input logic [7:0] v, input logic q, input string tag);
        push(0, 16'(v), tag);
        push(1, 16'(q), tag);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        push(2, exp, tag);
        tick();
        bus_rd = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic pulse(input int src);
        evt_i = '0;
        evt_i[src-1] = 1'b1;
        tick();
        evt_i = '0;
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        // R1: reset state
        expect_out(8'h00, 1'b0, "R1 outputs after reset");
        bus_read(2'd0, 16'h0000, "R1 config after reset");
        bus_read(2'd1, 16'h0000, "R1 status after reset");
        bus_read(2'd2, 16'h0000, "R1 enable after reset");

        // R2/R10: flag sets while disabled, no request
        pulse(3);
        bus_read(2'd1, 16'h0004, "R2 source 3 flag at bit 2");
        tick();
        expect_out(8'h00, 1'b0, "R10 disabled flag raises nothing");

        // R3/R4/R12: base 5, enable all
        bus_write(2'd0, 16'h0050);
        bus_write(2'd2, 16'h07FF);
        expect_out(8'h50, 1'b0, "R12 output lags enable by one edge");
        tick();
        expect_out(8'h53, 1'b1, "R3 R4 vector base 5 source 3");

        // R5: lowest number wins
        pulse(7);
        tick();
        expect_out(8'h53, 1'b1, "R5 source 3 beats 7");
        pulse(1);
        expect_out(8'h53, 1'b1, "R12 vector not yet updated");
        tick();
        expect_out(8'h51, 1'b1, "R5 source 1 beats 3 and 7");

        // R6: promotion
        bus_write(2'd0, 16'h0057);
        tick();
        expect_out(8'h57, 1'b1, "R6 promoted 7 wins");
        bus_write(2'd0, 16'h005C);
        tick();
        expect_out(8'h51, 1'b1, "R6 out-of-range code ignored");
        bus_write(2'd0, 16'h0059);
        tick();
        expect_out(8'h51, 1'b1, "R6 non-pending promoted source ignored");

        // R7: zero write with no read leaves flag
        bus_write(2'd1, 16'h07FE);
        bus_read(2'd1, 16'h0045, "R7 unarmed zero write keeps flags");

        // R7/R8: read arms (the read above armed 1,3,7), zero clears 1, ones keep
        bus_write(2'd1, 16'h07FE);
        tick();
        expect_out(8'h53, 1'b1, "R7 vector after clearing source 1");
        bus_read(2'd1, 16'h0044, "R7 R8 source 1 cleared, others kept");

        // R9: event between arming read and clearing write
        pulse(3);
        bus_write(2'd1, 16'h07FB);
        bus_read(2'd1, 16'h0044, "R9 intervening event keeps source 3");
        bus_write(2'd1, 16'h07FB);
        tick();
        bus_read(2'd1, 16'h0040, "R7 source 3 cleared after fresh read");
        expect_out(8'h57, 1'b1, "R5 only source 7 left");

        // R9: event in the same cycle as the clearing write (7 armed above)
        bus_addr = 2'd1; bus_wdata = 16'h07BF; bus_wr = 1'b1; evt_i[6] = 1'b1;
        tick();
        bus_wr = 1'b0; evt_i = '0; bus_addr = 2'd3;
        bus_read(2'd1, 16'h0040, "R9 same-cycle event keeps source 7");

        // R3: clear last flag, request drops
        bus_write(2'd1, 16'h07BF);
        bus_read(2'd1, 16'h0000, "R7 source 7 cleared");
        expect_out(8'h50, 1'b0, "R3 request drops with no flag");

        // R11: base zero passes through
        bus_write(2'd0, 16'h0000);
        pulse(11);
        tick();
        expect_out(8'h0B, 1'b1, "R11 base 0 gives vector 0x0B");

        // R10: disabling removes request and choice
        bus_write(2'd2, 16'h0000);
        tick();
        expect_out(8'h00, 1'b0, "R10 disabled source dropped");
        bus_read(2'd1, 16'h0400, "R10 flag 11 still held");

        tick();
        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule